// File: doc/BRIEF.md
# Soft-Start and Power-Good Sequencer

This block steps a switching regulator controller through its start-up. When the bias supply is above its undervoltage threshold and enable is high, the block waits a programmable number of oscillator clocks. It then checks two flags: a shorted feedback pin and an open timing resistor. If neither is set, it releases the soft-start ramp. The ramp level is modelled as a clock count. The block reports, in turn, when the ramp allows full synchronous rectification, when it reaches the reference, and when fault latching may be armed.

An open-drain power-good output is modelled as a pull-low request. Power-good is released only after the fault-enable point, and only while the feedback comparators report that the output is inside its regulation window. Light-load mode is granted only after the same point. Losing the supply or dropping enable returns the block to the start of the sequence.

The controller has five states: `PH_IDLE`, `PH_DELAY`, `PH_RAMP`, `PH_REGULATE` and `PH_ARMED`. Its transitions are:
- start: `PH_IDLE` to `PH_DELAY`, when the supply is good and the synchronized enable is high.
- release: `PH_DELAY` to `PH_RAMP`, when the delay count ends and neither blocking flag is set.
- reach: `PH_RAMP` to `PH_REGULATE`, at the reference count.
- arm: `PH_REGULATE` to `PH_ARMED`, at the fault-enable count.
- abort: any state to `PH_IDLE`, when the supply or the enable is lost.

Top module: `ss_sequencer`

## Requirements
- R1: While reset is asserted, `phase` is 5'b00001 (`PH_IDLE`), every marker output and `psm_en` are 0, and `pgood_pull_low` is 1.
- R2: The block leaves `PH_IDLE` only while `supply_ok` is 1 and the synchronized enable is 1. With `supply_ok` already 1, `phase` becomes 5'b00010 (`PH_DELAY`) on the third rising clock edge after `enable_in` rises.
- R3: `phase` stays at `PH_DELAY` for exactly DELAY_CLKS clock edges. After that it becomes 5'b00100 (`PH_RAMP`), provided no blocking flag is set.
- R4: While `fb_short` or `rt_open` is 1, the block never leaves `PH_DELAY` for `PH_RAMP`. Once both flags are 0 after the delay count has ended, `PH_RAMP` follows on the next edge.
- R5: `phase` becomes 5'b01000 (`PH_REGULATE`) and `ref_reached` rises exactly REF_CLKS edges after `PH_DELAY` was entered, when nothing blocked the start.
- R6: `phase` becomes 5'b10000 (`PH_ARMED`) and `fault_arm` rises exactly ARM_CLKS edges after `PH_DELAY` was entered. `psm_en` is 1 only in `PH_ARMED` while `psm_req` is 1.
- R7: `sync_rect_ok` rises exactly DELAY_CLKS + (REF_CLKS-DELAY_CLKS)*SR_PCT/100 edges after `PH_DELAY` was entered (SR_PCT defaults to 95). It stays 1 through `PH_REGULATE` and `PH_ARMED`.
- R8: If `supply_ok` is 0 at a clock edge, `phase` becomes `PH_IDLE` at that edge. A later start runs the full sequence again from a count of zero.
- R9: `pgood_pull_low` is 0 only in `PH_ARMED` while both `fb_low` and `fb_high` are 0. Otherwise it is 1.
- R10: Exactly one bit of `phase` is set in every cycle.
- R11: `enable_in` passes through two flip-flops. After `enable_in` falls, the phase changes to `PH_IDLE` on the third rising edge and not before. A low pulse on `enable_in` that the synchronizer captures also restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Bias supply above its undervoltage threshold (synchronous) |
| enable_in | input | 1 | Enable pin level (asynchronous) |
| fb_short | input | 1 | Feedback pin detected as shorted |
| rt_open | input | 1 | Frequency-setting resistor detected as open |
| fb_low | input | 1 | Feedback below the lower window threshold |
| fb_high | input | 1 | Feedback above the upper window threshold |
| psm_req | input | 1 | Light-load mode selected by the board |
| phase | output | 5 | One-hot phase: bit0 IDLE, bit1 DELAY, bit2 RAMP, bit3 REGULATE, bit4 ARMED |
| ref_reached | output | 1 | Ramp has reached the reference level |
| fault_arm | output | 1 | Fault latching is allowed |
| sync_rect_ok | output | 1 | Full synchronous rectification is allowed |
| psm_en | output | 1 | Light-load mode is granted |
| pgood_pull_low | output | 1 | Power-good open-drain pull-down is active |

## Verification
The assertions assume that `supply_ok`, `fb_short`, `rt_open`, `fb_low`, `fb_high` and `psm_req` are already synchronous to `clk`. Only `enable_in` may change at any time. They also assume that the parameters keep DELAY_CLKS below REF_CLKS and REF_CLKS below ARM_CLKS. The stimulus changes every input on the falling clock edge, so each input is stable at the rising edges. It uses the default phase counts, so the exact edge on which each marker rises is checked against the counts that are actually built.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_DELAY    = 3'd1,
        PH_RAMP     = 3'd2,
        PH_REGULATE = 3'd3,
        PH_ARMED    = 3'd4
    } seq_state_e;

    localparam int PHASE_W = 5;

endpackage

// File: rtl/ss_en_sync.sv
module ss_en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ss_pg_window.sv
module ss_pg_window (
    input  logic armed,
    input  logic fb_low,
    input  logic fb_high,
    output logic pull_low
);
    // Release the open-drain only when armed and inside the window.
    always_comb begin
        pull_low = 1'b1;
        if (armed && !fb_low && !fb_high) begin
            pull_low = 1'b0;
        end
    end
endmodule

// File: rtl/ss_sequencer.sv
module ss_sequencer
    import ss_seq_pkg::*;
#(
    parameter int DELAY_CLKS = 2400,
    parameter int REF_CLKS   = 3200,
    parameter int ARM_CLKS   = 4000,
    parameter int SR_PCT     = 95,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               supply_ok,
    input  logic               enable_in,
    input  logic               fb_short,
    input  logic               rt_open,
    input  logic               fb_low,
    input  logic               fb_high,
    input  logic               psm_req,
    output logic [PHASE_W-1:0] phase,
    output logic               ref_reached,
    output logic               fault_arm,
    output logic               sync_rect_ok,
    output logic               psm_en,
    output logic               pgood_pull_low
);
    localparam int CW     = $clog2(ARM_CLKS + 1);
    localparam int SR_AT  = DELAY_CLKS + ((REF_CLKS - DELAY_CLKS) * SR_PCT) / 100;
    localparam logic [CW-1:0] DLY_LAST = CW'(DELAY_CLKS - 1);
    localparam logic [CW-1:0] REF_LAST = CW'(REF_CLKS - 1);
    localparam logic [CW-1:0] ARM_LAST = CW'(ARM_CLKS - 1);
    localparam logic [CW-1:0] SR_CNT   = CW'(SR_AT);

    seq_state_e    state, nxt_state;
    logic [CW-1:0] cnt, nxt_cnt;
    logic          en_sync;
    logic          run_ok;
    logic          blocked;

    ss_en_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (enable_in),
        .sync_out (en_sync)
    );

    assign run_ok  = supply_ok && en_sync;
    assign blocked = fb_short || rt_open;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    // Transitions
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        unique case (state)
            PH_IDLE: begin
                nxt_cnt = '0;
                if (run_ok) begin
                    nxt_state = PH_DELAY;
                end
            end
            PH_DELAY: begin
                if (!run_ok) begin
                    nxt_state = PH_IDLE;
                    nxt_cnt   = '0;
                end else if (cnt == DLY_LAST) begin
                    if (!blocked) begin
                        nxt_state = PH_RAMP;
                        nxt_cnt   = cnt + 1'b1;
                    end
                end else begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            PH_RAMP: begin
                if (!run_ok) begin
                    nxt_state = PH_IDLE;
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt = cnt + 1'b1;
                    if (cnt == REF_LAST) begin
                        nxt_state = PH_REGULATE;
                    end
                end
            end
            PH_REGULATE: begin
                if (!run_ok) begin
                    nxt_state = PH_IDLE;
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt = cnt + 1'b1;
                    if (cnt == ARM_LAST) begin
                        nxt_state = PH_ARMED;
                    end
                end
            end
            PH_ARMED: begin
                if (!run_ok) begin
                    nxt_state = PH_IDLE;
                    nxt_cnt   = '0;
                end
            end
            default: begin
                nxt_state = PH_IDLE;
                nxt_cnt   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        phase        = '0;
        ref_reached  = 1'b0;
        fault_arm    = 1'b0;
        sync_rect_ok = 1'b0;
        unique case (state)
            PH_IDLE:  phase[0] = 1'b1;
            PH_DELAY: phase[1] = 1'b1;
            PH_RAMP: begin
                phase[2]     = 1'b1;
                sync_rect_ok = (cnt >= SR_CNT);
            end
            PH_REGULATE: begin
                phase[3]     = 1'b1;
                ref_reached  = 1'b1;
                sync_rect_ok = 1'b1;
            end
            PH_ARMED: begin
                phase[4]     = 1'b1;
                ref_reached  = 1'b1;
                fault_arm    = 1'b1;
                sync_rect_ok = 1'b1;
            end
            default: phase[0] = 1'b1;
        endcase
        psm_en = fault_arm && psm_req;
    end

    ss_pg_window u_pg (
        .armed    (fault_arm),
        .fb_low   (fb_low),
        .fb_high  (fb_high),
        .pull_low (pgood_pull_low)
    );

    // Assertions
    p_phase_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1);

    p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_IDLE && !(supply_ok && en_sync)) |=> state == PH_IDLE);

    p_hold_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_DELAY && blocked) |=> state != PH_RAMP);

    p_supply_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> state == PH_IDLE);

    p_ramp_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state == PH_RAMP |=> (state == PH_RAMP || state == PH_REGULATE || state == PH_IDLE));

    p_psm_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        psm_en |-> (fault_arm && psm_req));

    p_pgood_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pgood_pull_low |-> (fault_arm && !fb_low && !fb_high));

    p_sr_in_ramp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_rect_ok) |-> phase[2]);

    p_no_arm_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_arm) |-> $past(state) == PH_REGULATE);
endmodule

// File: tb/ss_sequencer_test.sv
module ss_sequencer_test;
    localparam int DLY = 2400;
    localparam int REF = 3200;
    localparam int ARM = 4000;
    localparam int SRP = DLY + ((REF - DLY) * 95) / 100;

    localparam logic [4:0] PH_I = 5'b00001;
    localparam logic [4:0] PH_D = 5'b00010;
    localparam logic [4:0] PH_R = 5'b00100;
    localparam logic [4:0] PH_G = 5'b01000;
    localparam logic [4:0] PH_A = 5'b10000;

    // {fb_low, fb_high, psm_req, exp_pull_low, exp_psm}
    localparam int NV = 6;
    localparam logic [4:0] VEC [0:NV-1] = '{
        5'b000_0_0, 5'b001_0_1, 5'b100_1_0,
        5'b011_1_1, 5'b110_1_0, 5'b101_1_1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, enable_in = 1'b0, fb_short = 1'b0, rt_open = 1'b0;
    logic fb_low = 1'b1, fb_high = 1'b0, psm_req = 1'b0;
    logic [4:0] phase;
    logic ref_reached, fault_arm, sync_rect_ok, psm_en, pgood_pull_low;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ss_sequencer uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable_in(enable_in),
        .fb_short(fb_short), .rt_open(rt_open), .fb_low(fb_low), .fb_high(fb_high),
        .psm_req(psm_req), .phase(phase), .ref_reached(ref_reached),
        .fault_arm(fault_arm), .sync_rect_ok(sync_rect_ok), .psm_en(psm_en),
        .pgood_pull_low(pgood_pull_low)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Starts from IDLE with enable low; returns on the cycle DELAY is entered.
    task automatic start_seq();
        supply_ok = 1'b1;
        enable_in = 1'b1;
        step(2);
        check("R2 not before sync", {27'd0, phase}, {27'd0, PH_I});
        step(1);
        check("R2 delay entered", {27'd0, phase}, {27'd0, PH_D});
    endtask

    task automatic run_to_armed();
        step(DLY - 1);
        check("R3 still delay", {27'd0, phase}, {27'd0, PH_D});
        step(1);
        check("R3 ramp", {27'd0, phase}, {27'd0, PH_R});
        step(SRP - DLY - 1);
        check("R7 sr low", {31'd0, sync_rect_ok}, 32'd0);
        step(1);
        check("R7 sr high", {31'd0, sync_rect_ok}, 32'd1);
        step(REF - SRP - 1);
        check("R5 not yet", {31'd0, ref_reached}, 32'd0);
        step(1);
        check("R5 regulate", {27'd0, phase}, {27'd0, PH_G});
        check("R7 sr in regulate", {31'd0, sync_rect_ok}, 32'd1);
        check("R9 no pgood before arm", {31'd0, pgood_pull_low}, 32'd1);
        step(ARM - REF - 1);
        check("R6 not armed", {31'd0, fault_arm}, 32'd0);
        step(1);
        check("R6 armed", {27'd0, phase}, {27'd0, PH_A});
        check("R6 fault_arm", {31'd0, fault_arm}, 32'd1);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(3);
        check("R1 phase", {27'd0, phase}, {27'd0, PH_I});
        check("R1 markers", {28'd0, ref_reached, fault_arm, sync_rect_ok, psm_en}, 32'd0);
        check("R1 pgood", {31'd0, pgood_pull_low}, 32'd1);
        rst_n = 1'b1;

        // R2: enable alone without supply does not start
        enable_in = 1'b1;
        step(6);
        check("R2 no supply", {27'd0, phase}, {27'd0, PH_I});
        enable_in = 1'b0;
        step(4);

        // Full sequence
        psm_req = 1'b1;
        start_seq();
        check("R6 psm before arm", {31'd0, psm_en}, 32'd0);
        run_to_armed();

        // R6/R9 table walk in ARMED
        for (int i = 0; i < NV; i++) begin
            fb_low  = VEC[i][4];
            fb_high = VEC[i][3];
            psm_req = VEC[i][2];
            step(1);
            check("R9 pgood table", {31'd0, pgood_pull_low}, {31'd0, VEC[i][1]});
            check("R6 psm table", {31'd0, psm_en}, {31'd0, VEC[i][0]});
            check("R10 onehot", $countones(phase), 32'd1);
        end

        // R11: enable falls, IDLE on the third edge
        enable_in = 1'b0;
        step(2);
        check("R11 not yet idle", {27'd0, phase}, {27'd0, PH_A});
        step(1);
        check("R11 idle", {27'd0, phase}, {27'd0, PH_I});
        check("R9 pgood after abort", {31'd0, pgood_pull_low}, 32'd1);

        // R4: shorted feedback holds DELAY
        fb_short = 1'b1;
        start_seq();
        step(DLY + 300);
        check("R4 short holds", {27'd0, phase}, {27'd0, PH_D});
        fb_short = 1'b0;
        step(1);
        check("R4 release", {27'd0, phase}, {27'd0, PH_R});

        // R8: supply loss in RAMP, restart from zero
        step(10);
        supply_ok = 1'b0;
        step(1);
        check("R8 supply abort", {27'd0, phase}, {27'd0, PH_I});
        supply_ok = 1'b1;
        step(1);
        check("R8 restart delay", {27'd0, phase}, {27'd0, PH_D});
        step(DLY - 1);
        check("R8 full delay", {27'd0, phase}, {27'd0, PH_D});
        step(1);
        check("R8 ramp after restart", {27'd0, phase}, {27'd0, PH_R});

        // R11: short enable low pulse (two clocks) restarts
        enable_in = 1'b0;
        step(2);
        enable_in = 1'b1;
        step(1);
        check("R11 pulse abort", {27'd0, phase}, {27'd0, PH_I});
        step(2);
        check("R11 pulse restart", {27'd0, phase}, {27'd0, PH_D});

        // R4: open timing resistor holds DELAY
        enable_in = 1'b0;
        step(3);
        rt_open = 1'b1;
        start_seq();
        step(DLY + 50);
        check("R4 rt open holds", {27'd0, phase}, {27'd0, PH_D});
        check("R7 no sr while held", {31'd0, sync_rect_ok}, 32'd0);
        rt_open = 1'b0;
        step(1);
        check("R4 rt release", {27'd0, phase}, {27'd0, PH_R});

        // R1: reset mid-sequence
        rst_n = 1'b0;
        step(1);
        check("R1 reset again", {27'd0, phase}, {27'd0, PH_I});
        check("R1 pgood again", {31'd0, pgood_pull_low}, 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule